// File: doc/BRIEF.md
# Packet Buffer Pointer Data Port

This block lets a host reach packet buffer memory one byte at a time. The host first writes a 16-bit pointer register, one byte per write. Then it writes data bytes through any of four data offsets. Each data byte becomes a single write into a packet memory, which is organised as packet number by byte address.

The packet number comes from one of two inputs, chosen by the top pointer bit: the head of the receive queue, or the value in the packet-number register. The byte address comes from the low eleven pointer bits.

Two addressing modes are available. In the incrementing mode, every data byte lands at the current address and the pointer then steps forward. The step wraps within eleven bits and never touches the control bits. In the fixed mode, the pointer stays put, and the data offset adds 0 to 3 to the address, so one pointer value covers a run of four bytes.

Top module: `ptr_data_port`

## Requirements
- R1: After reset, no memory write is issued and the pointer reads as 0x0000. The first data write therefore goes to the packet-number input at byte address 0.
- R2: A host write to bank 2 offset 6 loads pointer bits 7:0. A host write to bank 2 offset 7 loads pointer bits 15:8. Neither write changes the other byte.
- R3: For a data write, pointer bit 15 selects the packet:
  - when it is 1, `mem_pkt` takes the `rx_head_pkt` value present with the host write;
  - when it is 0, `mem_pkt` takes the `tx_pkt_num` value present with the host write.
- R4: The base byte address of a data write is pointer bits 10:0. Pointer bits 13:11 do not affect the address.
- R5: When pointer bit 14 is 1, a data write uses the base address unchanged. Afterwards, pointer bits 10:0 increment modulo 2048 and bits 15:11 keep their value. For example, 0xC7FF becomes 0xC000.
- R6: When pointer bit 14 is 0, the pointer is not changed by a data write. The address is (base + (offset AND 3)) modulo 2048. For example, base 0x7FE with offset 11 gives address 0x001.
- R7: Host writes to bank 2 at offsets 8, 9, 10 and 11 are all data writes. The host byte appears on `mem_wdata`.
- R8: Each data write raises `mem_we` for exactly one cycle. That cycle is the cycle after the host write, and `mem_pkt`, `mem_addr` and `mem_wdata` are valid in it. `mem_we` is low in every other cycle.
- R9: Host writes to any other bank, or to any bank-2 offset outside 6 to 11, change nothing: the pointer keeps its value and no memory write is issued.
- R10: Pointer byte writes never raise `mem_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host byte write strobe, one cycle per write |
| host_bank | input | 2 | Register bank of the host write |
| host_ofs | input | 4 | Byte offset within the bank |
| host_wdata | input | 8 | Host write byte |
| rx_head_pkt | input | 6 | Packet number at the head of the receive queue |
| tx_pkt_num | input | 6 | Value of the packet-number register |
| mem_we | output | 1 | Packet memory write strobe |
| mem_pkt | output | 6 | Packet number of the memory write |
| mem_addr | output | 11 | Byte address within the packet |
| mem_wdata | output | 8 | Byte to write |

## Verification
The hardest case to reach from the ports is the eleven-bit wrap: an incrementing pointer at 0x7FF with nonzero control bits, and a fixed pointer near the top of the window combined with a large data offset. Random pointer loads rarely land there. Directed sequences therefore load 0xC7FF and 0x07FE explicitly and then issue back-to-back data writes. Random traffic mixes the modes, the banks and the unused offsets around those cases, and a bench model of the pointer predicts every address.

// File: rtl/ptr_port_pkg.sv
package ptr_port_pkg;
  localparam int HOST_BANK_W = 2;
  localparam int HOST_OFS_W  = 4;
  localparam int BYTE_W      = 8;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_PTRLO = 2'd1,
    ACC_PTRHI = 2'd2,
    ACC_DATA  = 2'd3
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e  kind;
    logic [1:0] byte_sel;
  } host_acc_t;
endpackage

// File: rtl/ptr_host_decode.sv
module ptr_host_decode
  import ptr_port_pkg::*;
#(
  parameter int unsigned BANK_ID  = 2,
  parameter int unsigned OFS_PLO  = 6,
  parameter int unsigned OFS_PHI  = 7,
  parameter int unsigned OFS_DAT0 = 8
) (
  input  logic                   host_wr,
  input  logic [HOST_BANK_W-1:0] host_bank,
  input  logic [HOST_OFS_W-1:0]  host_ofs,
  output host_acc_t              acc
);
  localparam int unsigned OFS_DAT3 = OFS_DAT0 + 3;

  logic in_bank;

  always_comb begin
    in_bank      = host_wr && (host_bank == HOST_BANK_W'(BANK_ID));
    acc.kind     = ACC_NONE;
    acc.byte_sel = host_ofs[1:0];
    if (in_bank) begin
      if (host_ofs == HOST_OFS_W'(OFS_PLO)) begin
        acc.kind = ACC_PTRLO;
      end else if (host_ofs == HOST_OFS_W'(OFS_PHI)) begin
        acc.kind = ACC_PTRHI;
      end else if ((host_ofs >= HOST_OFS_W'(OFS_DAT0)) &&
                   (host_ofs <= HOST_OFS_W'(OFS_DAT3))) begin
        acc.kind = ACC_DATA;
      end
    end
  end
endmodule

// File: rtl/ptr_reg.sv
module ptr_reg
  import ptr_port_pkg::*;
#(
  parameter int unsigned PTR_W   = 16,
  parameter int unsigned ADDR_W  = 11,
  parameter int unsigned INC_BIT = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  host_acc_t         acc,
  input  logic [BYTE_W-1:0] din,
  output logic [PTR_W-1:0]  ptr_q
);
  localparam int unsigned CTL_W = PTR_W - ADDR_W;

  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    unique case (acc.kind)
      ACC_PTRLO: begin
        ptr_d[BYTE_W-1:0] = din;
        ptr_en            = 1'b1;
      end
      ACC_PTRHI: begin
        ptr_d[PTR_W-1:BYTE_W] = din[PTR_W-BYTE_W-1:0];
        ptr_en                = 1'b1;
      end
      ACC_DATA: begin
        if (ptr_q[INC_BIT]) begin
          ptr_d  = {ptr_q[PTR_W-1:ADDR_W], ptr_q[ADDR_W-1:0] + ADDR_W'(1)};
          ptr_en = 1'b1;
        end
      end
      default: ptr_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  a_r5_ctl_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.kind == ACC_DATA && ptr_q[INC_BIT]) |=>
      (ptr_q[PTR_W-1:ADDR_W] == $past(ptr_q[PTR_W-1:ADDR_W])) &&
      (ptr_q[ADDR_W-1:0] == $past(ptr_q[ADDR_W-1:0]) + ADDR_W'(1)));

  a_r6_fixed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.kind == ACC_DATA && !ptr_q[INC_BIT]) |=> $stable(ptr_q));

  a_r2_low_load: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.kind == ACC_PTRLO) |=>
      (ptr_q[BYTE_W-1:0] == $past(din)) &&
      (ptr_q[PTR_W-1:BYTE_W] == $past(ptr_q[PTR_W-1:BYTE_W])));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.kind == ACC_NONE) |=> $stable(ptr_q));

  if (CTL_W < 2) begin : g_bad_cfg
    initial $error("ptr_reg: pointer needs room for control bits");
  end
endmodule

// File: rtl/ptr_mem_issue.sv
module ptr_mem_issue
  import ptr_port_pkg::*;
#(
  parameter int unsigned PTR_W   = 16,
  parameter int unsigned ADDR_W  = 11,
  parameter int unsigned PKT_W   = 6,
  parameter int unsigned SEL_BIT = 15,
  parameter int unsigned INC_BIT = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  host_acc_t         acc,
  input  logic [PTR_W-1:0]  ptr_q,
  input  logic [BYTE_W-1:0] din,
  input  logic [PKT_W-1:0]  rx_head_pkt,
  input  logic [PKT_W-1:0]  tx_pkt_num,
  output logic              mem_we,
  output logic [PKT_W-1:0]  mem_pkt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata
);
  logic              we_d;
  logic [PKT_W-1:0]  pkt_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    we_d  = (acc.kind == ACC_DATA);
    pkt_d = ptr_q[SEL_BIT] ? rx_head_pkt : tx_pkt_num;
    if (ptr_q[INC_BIT]) addr_d = ptr_q[ADDR_W-1:0];
    else addr_d = ptr_q[ADDR_W-1:0] + ADDR_W'(acc.byte_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_we <= 1'b0;
    else mem_we <= we_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_pkt   <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (we_d) begin
      mem_pkt   <= pkt_d;
      mem_addr  <= addr_d;
      mem_wdata <= din;
    end
  end

  a_r3_rx_select: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.kind == ACC_DATA && ptr_q[SEL_BIT]) |=> (mem_pkt == $past(rx_head_pkt)));

  a_r4_inc_base: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.kind == ACC_DATA && ptr_q[INC_BIT]) |=> (mem_addr == $past(ptr_q[ADDR_W-1:0])));
endmodule

// File: rtl/ptr_data_port.sv
module ptr_data_port
  import ptr_port_pkg::*;
#(
  parameter int unsigned PKT_W   = 6,
  parameter int unsigned ADDR_W  = 11,
  parameter int unsigned PTR_W   = 16,
  parameter int unsigned BANK_ID = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_wr,
  input  logic [HOST_BANK_W-1:0] host_bank,
  input  logic [HOST_OFS_W-1:0]  host_ofs,
  input  logic [BYTE_W-1:0]      host_wdata,
  input  logic [PKT_W-1:0]       rx_head_pkt,
  input  logic [PKT_W-1:0]       tx_pkt_num,
  output logic                   mem_we,
  output logic [PKT_W-1:0]       mem_pkt,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [BYTE_W-1:0]      mem_wdata
);
  localparam int unsigned SEL_BIT = PTR_W - 1;
  localparam int unsigned INC_BIT = PTR_W - 2;

  host_acc_t        acc;
  logic [PTR_W-1:0] ptr_q;

  ptr_host_decode #(.BANK_ID(BANK_ID)) u_dec (
    .host_wr  (host_wr),
    .host_bank(host_bank),
    .host_ofs (host_ofs),
    .acc      (acc)
  );

  ptr_reg #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .INC_BIT(INC_BIT)) u_ptr (
    .clk  (clk),
    .rst_n(rst_n),
    .acc  (acc),
    .din  (host_wdata),
    .ptr_q(ptr_q)
  );

  ptr_mem_issue #(
    .PTR_W(PTR_W), .ADDR_W(ADDR_W), .PKT_W(PKT_W),
    .SEL_BIT(SEL_BIT), .INC_BIT(INC_BIT)
  ) u_iss (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc        (acc),
    .ptr_q      (ptr_q),
    .din        (host_wdata),
    .rx_head_pkt(rx_head_pkt),
    .tx_pkt_num (tx_pkt_num),
    .mem_we     (mem_we),
    .mem_pkt    (mem_pkt),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
  );

  a_r8_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.kind == ACC_DATA) |=> mem_we);

  a_r8_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.kind != ACC_DATA) |=> !mem_we);

  a_r10_ptr_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.kind == ACC_PTRLO || acc.kind == ACC_PTRHI) |=> !mem_we);
endmodule

// File: tb/ptr_data_port_test.sv
module ptr_data_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic [1:0] host_bank = '0;
  logic [3:0] host_ofs = '0;
  logic [7:0] host_wdata = '0;
  logic [5:0] rx_head_pkt = '0;
  logic [5:0] tx_pkt_num = '0;
  logic       mem_we;
  logic [5:0] mem_pkt;
  logic [10:0] mem_addr;
  logic [7:0] mem_wdata;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] ptr_m;

  always #10 clk = ~clk;

  ptr_data_port uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_bank(host_bank),
    .host_ofs(host_ofs), .host_wdata(host_wdata), .rx_head_pkt(rx_head_pkt),
    .tx_pkt_num(tx_pkt_num), .mem_we(mem_we), .mem_pkt(mem_pkt),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  function automatic logic [10:0] exp_addr(logic [15:0] p, logic [3:0] ofs);
    if (p[14]) return p[10:0];
    return p[10:0] + {9'd0, ofs[1:0]};
  endfunction

  function automatic logic [15:0] exp_ptr(logic [15:0] p, logic [1:0] bank,
                                          logic [3:0] ofs, logic [7:0] d);
    if (bank != 2'd2) return p;
    if (ofs == 4'd6) return {p[15:8], d};
    if (ofs == 4'd7) return {d, p[7:0]};
    if (ofs >= 4'd8 && ofs <= 4'd11 && p[14]) return {p[15:11], p[10:0] + 11'd1};
    return p;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [1:0] bank, logic [3:0] ofs, logic [7:0] d);
    logic [5:0] rxv, pnv;
    logic       is_data;
    rxv = 6'($urandom);
    pnv = 6'($urandom);
    @(negedge clk);
    host_wr = 1'b1; host_bank = bank; host_ofs = ofs; host_wdata = d;
    rx_head_pkt = rxv; tx_pkt_num = pnv;
    is_data = (bank == 2'd2) && (ofs >= 4'd8) && (ofs <= 4'd11);
    @(negedge clk);
    host_wr = 1'b0;
    if (is_data) begin
      chk("R8 strobe", 32'(mem_we), 32'd1);
      chk("R3 pkt", 32'(mem_pkt), 32'(ptr_m[15] ? rxv : pnv));
      chk(ptr_m[14] ? "R5 addr" : "R6 addr", 32'(mem_addr), 32'(exp_addr(ptr_m, ofs)));
      chk("R7 data", 32'(mem_wdata), 32'(d));
    end else if (bank == 2'd2 && (ofs == 4'd6 || ofs == 4'd7)) begin
      chk("R10 no strobe", 32'(mem_we), 32'd0);
    end else begin
      chk("R9 ignored", 32'(mem_we), 32'd0);
    end
    ptr_m = exp_ptr(ptr_m, bank, ofs, d);
  endtask

  task automatic set_ptr(logic [15:0] v);
    hwrite(2'd2, 4'd6, v[7:0]);
    hwrite(2'd2, 4'd7, v[15:8]);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    ptr_m = 16'h0000;
    repeat (3) @(negedge clk);
    chk("R1 reset strobe", 32'(mem_we), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset strobe", 32'(mem_we), 32'd0);
    // R1: first data write goes to the packet-number input, address 0
    hwrite(2'd2, 4'd8, 8'hA5);
    // R8: strobe low in the following idle cycle
    @(negedge clk);
    chk("R8 one cycle", 32'(mem_we), 32'd0);
    // R5: wrap at 0x7FF keeps control bits
    set_ptr(16'hC7FF);
    hwrite(2'd2, 4'd9, 8'h11);
    hwrite(2'd2, 4'd10, 8'h22);
    // R6: fixed mode wrap of base plus offset
    set_ptr(16'h07FE);
    hwrite(2'd2, 4'd11, 8'h33);
    hwrite(2'd2, 4'd8, 8'h44);
    // R4: bits 13:11 ignored in address
    set_ptr(16'h3A05);
    hwrite(2'd2, 4'd9, 8'h55);
    // R9: other banks and offsets leave pointer alone
    hwrite(2'd1, 4'd6, 8'hFF);
    hwrite(2'd0, 4'd8, 8'hFF);
    hwrite(2'd2, 4'd12, 8'hFF);
    hwrite(2'd2, 4'd10, 8'h66);
    // R2: high byte load does not disturb low byte
    hwrite(2'd2, 4'd7, 8'h80);
    hwrite(2'd2, 4'd8, 8'h77);
    for (int i = 0; i < 600; i++) begin
      logic [3:0] ofs;
      logic [1:0] bank;
      bank = ($urandom % 8 == 0) ? 2'($urandom) : 2'd2;
      ofs  = ($urandom % 6 == 0) ? 4'($urandom) : 4'(6 + $urandom % 6);
      hwrite(bank, ofs, 8'($urandom));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule